// File: doc/BRIEF.md
# I2C Write-Then-Read Transaction Sequencer

This block drives a single I2C bus as master and walks it through one programmed transaction at a time. Three forms are supported: a run of writes, a run of reads, and a combined transfer in which a write phase is followed by a read phase. In the combined form the two phases are joined by a repeated start, so no stop appears between them. Software sets the target address, the direction, a packed length word, a transaction count and a control byte, then pulses `go`. All of these settings are captured on that pulse.

Outgoing data bytes arrive on a valid/ready stream. The block raises `tx_ready` only when it needs the next byte, and it holds SCL low until `tx_valid` answers. Received bytes leave on a second valid/ready stream. `rx_valid` and `rx_data` stay fixed until `rx_ready` is high. During that wait SCL stays low, so a slow consumer stalls the bus and no data is lost.

Bus timing comes from a quarter-bit strobe `bit_tick` supplied by an external timing generator. Each bus primitive (start, repeated start, stop, one bit) lasts four strobes. A one-cycle `xfer_done` marks the end of every transaction, including a failed one. A one-cycle `ack_err` marks an acknowledge failure.

Top module: `i2c_wr_seq`

## Requirements
- R1: After reset, and while idle, `scl_o` and `sda_o` are both 1 (released), `busy` is 0, and neither `xfer_done` nor `ack_err` is high.
- R2: Every address byte on the bus is `{tgt_addr, dir}`, sent MSB first, where dir is 1 for a read phase and 0 for a write phase.
- R3: Write-phase data bytes are taken from the TX stream in order and sent MSB first. `tx_ready` is high only while SCL is held low.
- R4: When `ctl[4]` is 1 and `txn_cnt` is 2, the block runs a combined transfer. It writes `xfer_len[7:0]` bytes, issues a repeated start with no stop, resends the address with the read bit, and reads the read-phase count. A single stop ends the transfer.
- R5: The master acknowledges (SDA 0) every received byte except the last byte of a read phase, which it answers with SDA 1.
- R6: The write length is the full `xfer_len[7:0]` (0 to 255). The read length of a combined transfer is `xfer_len[12:8]` (0 to 31), and bits 15:13 are ignored.
- R7: With `ctl[5]` = 1, a NACK on an address or write byte pulses `ack_err`. The block then sends no further bytes, issues a stop, and afterwards pulses `xfer_done`.
- R8: With `ctl[5]` = 0, a NACK is ignored and the transaction completes in full without `ack_err`.
- R9: Outside combined mode, `txn_cnt` = N > 1 repeats the programmed transaction N times. Between repeats the block uses a repeated start when `ctl[1]` = 1, and a stop followed by a start when `ctl[1]` = 0.
- R10: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold their values and SCL stays low.
- R11: A `go` pulse with `txn_cnt` = 0 pulses `xfer_done` without any bus activity.
- R12: `xfer_done` is a one-cycle pulse, given exactly once per `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Quarter-bit timing strobe |
| tgt_addr | input | 7 | Target address |
| rd_op | input | 1 | Direction of a non-combined transaction (1 = read) |
| xfer_len | input | 16 | [7:0] write or single length, [12:8] read length of combined transfer |
| txn_cnt | input | 8 | Transaction count |
| ctl | input | 8 | Bit 1 repeated start, bit 4 direction change, bit 5 NACK detection |
| go | input | 1 | Start pulse, sampled while idle |
| tx_valid | input | 1 | TX byte available |
| tx_ready | output | 1 | Block accepts a TX byte |
| tx_data | input | 8 | TX byte |
| rx_valid | output | 1 | RX byte available |
| rx_ready | input | 1 | Consumer accepts the RX byte |
| rx_data | output | 8 | RX byte |
| scl_o | output | 1 | SCL level, 1 = released |
| sda_o | output | 1 | SDA level driven by master, 1 = released |
| sda_i | input | 1 | Sampled SDA bus level |
| busy | output | 1 | Transaction in progress |
| xfer_done | output | 1 | Transaction-complete pulse |
| ack_err | output | 1 | Acknowledge-error pulse |

## Verification
The hardest case to reach from the ports is an acknowledge failure in the middle of a transaction. It needs a target that refuses one specific byte while the block is partway through a write. The bench contains a behavioural target on the open-drain bus. It can NACK its own address or the Nth data byte. This lets the bench test the abort path and the NACK-ignored path on the same byte position, and confirm whether the remaining TX bytes were consumed. A second hard case is holding the bus mid-read. The bench does this by keeping `rx_ready` low for hundreds of cycles while it watches SCL.

// File: rtl/i2c_wr_seq_pkg.sv
package i2c_wr_seq_pkg;

  typedef enum logic [2:0] {
    BUS_START,
    BUS_RESTART,
    BUS_STOP,
    BUS_WRITE,
    BUS_READ
  } bus_op_e;

  localparam int CTL_RS_BIT     = 1;
  localparam int CTL_DIR_BIT    = 4;
  localparam int CTL_ACKDET_BIT = 5;

  typedef struct packed {
    logic combined;
    logic first_rd;
    logic rs_en;
    logic ackdet_en;
  } xfer_mode_t;

endpackage

// File: rtl/i2c_wr_seq_plan.sv
module i2c_wr_seq_plan
  import i2c_wr_seq_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int RD_LEN_W = 5,
  parameter int CNT_W    = 8,
  parameter int CTL_W    = 8
) (
  input  logic               rd_op_i,
  input  logic [2*LEN_W-1:0] xfer_len_i,
  input  logic [CNT_W-1:0]   txn_cnt_i,
  input  logic [CTL_W-1:0]   ctl_i,
  output xfer_mode_t         mode_o,
  output logic [LEN_W-1:0]   len_wr_o,
  output logic [LEN_W-1:0]   len_rd_o,
  output logic [CNT_W-1:0]   txn_total_o
);

  localparam logic [CNT_W-1:0] TWO_TXN = CNT_W'(2);

  logic combined;
  assign combined = ctl_i[CTL_DIR_BIT] && (txn_cnt_i == TWO_TXN);

  assign mode_o.combined  = combined;
  assign mode_o.first_rd  = combined ? 1'b0 : rd_op_i;
  assign mode_o.rs_en     = ctl_i[CTL_RS_BIT];
  assign mode_o.ackdet_en = ctl_i[CTL_ACKDET_BIT];

  assign len_wr_o    = xfer_len_i[LEN_W-1:0];
  assign txn_total_o = combined ? CNT_W'(1) : txn_cnt_i;

  generate
    if (RD_LEN_W < LEN_W) begin : g_rd_narrow
      assign len_rd_o = {{(LEN_W-RD_LEN_W){1'b0}}, xfer_len_i[LEN_W +: RD_LEN_W]};
    end else begin : g_rd_full
      assign len_rd_o = xfer_len_i[LEN_W +: LEN_W];
    end
  endgenerate

endmodule

// File: rtl/i2c_wr_seq_bit_engine.sv
module i2c_wr_seq_bit_engine
  import i2c_wr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  logic    cmd_valid_i,
  input  bus_op_e cmd_i,
  input  logic    cmd_bit_i,
  output logic    cmd_ready_o,
  output logic    bit_done_o,
  output logic    rx_bit_o,
  input  logic    sda_i,
  output logic    scl_o,
  output logic    sda_o
);

  // returns {scl, sda} for a primitive in a given quarter phase
  function automatic logic [1:0] levels(bus_op_e op, logic b, logic [1:0] ph);
    logic [1:0] lv;
    case (op)
      BUS_START:   lv = (ph == 2'd0) ? 2'b11 : (ph == 2'd3) ? 2'b00 : 2'b10;
      BUS_RESTART: lv = (ph == 2'd0) ? 2'b01 : (ph == 2'd1) ? 2'b11 :
                        (ph == 2'd2) ? 2'b10 : 2'b00;
      BUS_STOP:    lv = (ph == 2'd0) ? 2'b00 : (ph == 2'd1) ? 2'b10 : 2'b11;
      default:     lv = {(ph == 2'd1) || (ph == 2'd2), b};
    endcase
    return lv;
  endfunction

  logic       active_q;
  logic [1:0] ph_q;
  bus_op_e    op_q;
  logic       bit_q;
  logic       scl_q, sda_q;

  assign cmd_ready_o = !active_q;
  assign scl_o = scl_q;
  assign sda_o = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      ph_q       <= 2'd0;
      op_q       <= BUS_STOP;
      bit_q      <= 1'b1;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      bit_done_o <= 1'b0;
      rx_bit_o   <= 1'b1;
    end else begin
      bit_done_o <= 1'b0;
      if (!active_q && cmd_valid_i) begin
        active_q       <= 1'b1;
        ph_q           <= 2'd0;
        op_q           <= cmd_i;
        bit_q          <= cmd_bit_i;
        {scl_q, sda_q} <= levels(cmd_i, cmd_bit_i, 2'd0);
      end else if (active_q && tick_i) begin
        if (ph_q == 2'd1) rx_bit_o <= sda_i;
        if (ph_q == 2'd3) begin
          active_q   <= 1'b0;
          bit_done_o <= 1'b1;
        end else begin
          ph_q           <= ph_q + 2'd1;
          {scl_q, sda_q} <= levels(op_q, bit_q, ph_q + 2'd1);
        end
      end
    end
  end

  // R10
  bus_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !cmd_valid_i) |=> ($stable(scl_q) && $stable(sda_q)));

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done_o |-> cmd_ready_o);

endmodule

// File: rtl/i2c_wr_seq_ctrl.sv
module i2c_wr_seq_ctrl
  import i2c_wr_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  xfer_mode_t        mode_i,
  input  logic [LEN_W-1:0]  len_wr_i,
  input  logic [LEN_W-1:0]  len_rd_i,
  input  logic [CNT_W-1:0]  txn_total_i,
  // bit engine
  output logic              cmd_valid_o,
  output bus_op_e           cmd_o,
  output logic              cmd_bit_o,
  input  logic              cmd_ready_i,
  input  logic              bit_done_i,
  input  logic              rx_bit_i,
  // streams
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [7:0]        tx_data_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [7:0]        rx_data_o,
  // status
  output logic              busy_o,
  output logic              done_o,
  output logic              ackerr_o
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_RESTART, S_ADDR, S_AACK, S_TXWAIT, S_WBIT,
    S_WACK, S_RBIT, S_RPUSH, S_MACK, S_NEXT, S_STOP, S_FIN
  } st_e;

  localparam logic [LEN_W-1:0] ONE_B = LEN_W'(1);
  localparam logic [CNT_W-1:0] ONE_T = CNT_W'(1);

  st_e               st_q;
  logic              pend_q;
  logic [7:0]        sh_q;
  logic [2:0]        bitc_q;
  logic [LEN_W-1:0]  left_q;
  logic [LEN_W-1:0]  len_wr_q, len_rd_q;
  logic [CNT_W-1:0]  txn_q;
  logic [ADDR_W-1:0] addr_q;
  logic              comb_q, rd_q, rs_q, det_q, more_q, err_q;

  logic bus_state;
  always_comb begin
    cmd_o     = BUS_WRITE;
    cmd_bit_o = 1'b1;
    bus_state = 1'b1;
    case (st_q)
      S_START:                 cmd_o = BUS_START;
      S_RESTART:               cmd_o = BUS_RESTART;
      S_STOP:                  cmd_o = BUS_STOP;
      S_ADDR, S_WBIT:          cmd_bit_o = sh_q[7];
      S_AACK, S_WACK, S_RBIT:  cmd_o = BUS_READ;
      S_MACK:                  cmd_bit_o = (left_q == ONE_B);
      default:                 bus_state = 1'b0;
    endcase
    cmd_valid_o = bus_state && !pend_q;
  end

  assign tx_ready_o = (st_q == S_TXWAIT);
  assign rx_valid_o = (st_q == S_RPUSH);
  assign rx_data_o  = sh_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_FIN);
  assign ackerr_o   = err_q;

  logic nack_hit;
  assign nack_hit = rx_bit_i && det_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pend_q   <= 1'b0;
      sh_q     <= '0;
      bitc_q   <= '0;
      left_q   <= '0;
      len_wr_q <= '0;
      len_rd_q <= '0;
      txn_q    <= '0;
      addr_q   <= '0;
      comb_q   <= 1'b0;
      rd_q     <= 1'b0;
      rs_q     <= 1'b0;
      det_q    <= 1'b0;
      more_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (cmd_valid_o && cmd_ready_i) pend_q <= 1'b1;
      if (bit_done_i) pend_q <= 1'b0;
      case (st_q)
        S_IDLE: if (go_i) begin
          addr_q   <= addr_i;
          comb_q   <= mode_i.combined;
          rd_q     <= mode_i.first_rd;
          rs_q     <= mode_i.rs_en;
          det_q    <= mode_i.ackdet_en;
          len_wr_q <= len_wr_i;
          len_rd_q <= len_rd_i;
          left_q   <= len_wr_i;
          txn_q    <= txn_total_i;
          more_q   <= 1'b0;
          st_q     <= (txn_total_i == '0) ? S_FIN : S_START;
        end
        S_START, S_RESTART: if (bit_done_i) begin
          sh_q   <= {addr_q, rd_q};
          bitc_q <= 3'd7;
          st_q   <= S_ADDR;
        end
        S_ADDR, S_WBIT: if (bit_done_i) begin
          if (bitc_q == 3'd0) st_q <= (st_q == S_ADDR) ? S_AACK : S_WACK;
          else begin
            sh_q   <= {sh_q[6:0], 1'b0};
            bitc_q <= bitc_q - 3'd1;
          end
        end
        S_AACK: if (bit_done_i) begin
          if (nack_hit) begin
            err_q  <= 1'b1;
            more_q <= 1'b0;
            st_q   <= S_STOP;
          end else if (left_q == '0) st_q <= S_NEXT;
          else if (rd_q) begin
            bitc_q <= 3'd7;
            st_q   <= S_RBIT;
          end else st_q <= S_TXWAIT;
        end
        S_TXWAIT: if (tx_valid_i) begin
          sh_q   <= tx_data_i;
          bitc_q <= 3'd7;
          st_q   <= S_WBIT;
        end
        S_WACK: if (bit_done_i) begin
          if (nack_hit) begin
            err_q  <= 1'b1;
            more_q <= 1'b0;
            st_q   <= S_STOP;
          end else begin
            left_q <= left_q - ONE_B;
            st_q   <= (left_q == ONE_B) ? S_NEXT : S_TXWAIT;
          end
        end
        S_RBIT: if (bit_done_i) begin
          sh_q <= {sh_q[6:0], rx_bit_i};
          if (bitc_q == 3'd0) st_q <= S_RPUSH;
          else bitc_q <= bitc_q - 3'd1;
        end
        S_RPUSH: if (rx_ready_i) st_q <= S_MACK;
        S_MACK: if (bit_done_i) begin
          left_q <= left_q - ONE_B;
          bitc_q <= 3'd7;
          st_q   <= (left_q == ONE_B) ? S_NEXT : S_RBIT;
        end
        S_NEXT: begin
          if (comb_q && !rd_q) begin
            rd_q   <= 1'b1;
            left_q <= len_rd_q;
            st_q   <= S_RESTART;
          end else if (txn_q == ONE_T) begin
            more_q <= 1'b0;
            st_q   <= S_STOP;
          end else begin
            txn_q  <= txn_q - ONE_T;
            left_q <= len_wr_q;
            if (rs_q) st_q <= S_RESTART;
            else begin
              more_q <= 1'b1;
              st_q   <= S_STOP;
            end
          end
        end
        S_STOP: if (bit_done_i) begin
          more_q <= 1'b0;
          st_q   <= more_q ? S_START : S_FIN;
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackerr_o |=> (busy_o && !done_o));

endmodule

// File: rtl/i2c_wr_seq.sv
module i2c_wr_seq
  import i2c_wr_seq_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int LEN_W    = 8,
  parameter int RD_LEN_W = 5,
  parameter int CNT_W    = 8,
  parameter int CTL_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic [ADDR_W-1:0]  tgt_addr,
  input  logic               rd_op,
  input  logic [2*LEN_W-1:0] xfer_len,
  input  logic [CNT_W-1:0]   txn_cnt,
  input  logic [CTL_W-1:0]   ctl,
  input  logic               go,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [7:0]         tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [7:0]         rx_data,
  output logic               scl_o,
  output logic               sda_o,
  input  logic               sda_i,
  output logic               busy,
  output logic               xfer_done,
  output logic               ack_err
);

  xfer_mode_t       mode;
  logic [LEN_W-1:0] len_wr, len_rd;
  logic [CNT_W-1:0] txn_total;
  logic             cmd_valid, cmd_bit, cmd_ready, bit_done, rx_bit;
  bus_op_e          cmd;

  i2c_wr_seq_plan #(.LEN_W(LEN_W), .RD_LEN_W(RD_LEN_W), .CNT_W(CNT_W), .CTL_W(CTL_W)) u_plan (
    .rd_op_i(rd_op), .xfer_len_i(xfer_len), .txn_cnt_i(txn_cnt), .ctl_i(ctl),
    .mode_o(mode), .len_wr_o(len_wr), .len_rd_o(len_rd), .txn_total_o(txn_total)
  );

  i2c_wr_seq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go_i(go), .addr_i(tgt_addr), .mode_i(mode),
    .len_wr_i(len_wr), .len_rd_i(len_rd), .txn_total_i(txn_total),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_bit_o(cmd_bit),
    .cmd_ready_i(cmd_ready), .bit_done_i(bit_done), .rx_bit_i(rx_bit),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .busy_o(busy), .done_o(xfer_done), .ackerr_o(ack_err)
  );

  i2c_wr_seq_bit_engine u_bits (
    .clk(clk), .rst_n(rst_n), .tick_i(bit_tick),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .cmd_bit_i(cmd_bit),
    .cmd_ready_o(cmd_ready), .bit_done_o(bit_done), .rx_bit_o(rx_bit),
    .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o)
  );

  // R3
  tx_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !scl_o);

  // R10
  rx_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !scl_o);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !xfer_done) |-> (scl_o && sda_o));

endmodule

// File: tb/i2c_wr_seq_test.sv
module i2c_wr_seq_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  tdiv = 2'd0;
  logic        bit_tick;
  logic [6:0]  tgt_addr = '0;
  logic        rd_op = 1'b0;
  logic [15:0] xfer_len = '0;
  logic [7:0]  txn_cnt = '0;
  logic [7:0]  ctl = '0;
  logic        go = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [7:0]  rx_data;
  logic        scl_o, sda_o, sda_i;
  logic        busy, xfer_done, ack_err;
  logic        slv_sda = 1'b1;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign bit_tick = (tdiv == 2'd3);
  assign sda_i = sda_o & slv_sda;

  i2c_wr_seq uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tgt_addr(tgt_addr),
    .rd_op(rd_op), .xfer_len(xfer_len), .txn_cnt(txn_cnt), .ctl(ctl), .go(go),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i),
    .busy(busy), .xfer_done(xfer_done), .ack_err(ack_err)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_wr[$];
  logic [7:0] exp_rd[$];
  logic [7:0] tx_q[$];
  int rd_k = 0;
  int exp_k = 0;

  // target model state
  bit p_scl = 1, p_sda = 1;
  int mode = 0, nxt_mode = 0, bitc = 0, wr_idx = 0;
  int nack_idx = -1;
  bit nack_addr = 0, rd_stop = 0;
  logic [7:0] sh = '0, rd_byte = '0;
  int starts = 0, stops = 0, m_acks = 0, m_nacks = 0;

  always @(posedge clk) begin
    bit cs, cd, ack;
    cs = scl_o;
    cd = sda_i;
    if (p_scl && cs && p_sda && !cd) begin
      starts++; mode = 1; bitc = 0; rd_stop = 0; slv_sda <= 1'b1;
    end else if (p_scl && cs && !p_sda && cd) begin
      stops++; mode = 0; slv_sda <= 1'b1;
    end else if (!p_scl && cs && mode != 0) begin
      if (bitc < 8) sh = {sh[6:0], cd};
      else if (mode == 3) begin
        if (cd) begin m_nacks++; rd_stop = 1; end
        else m_acks++;
      end
      bitc++;
    end else if (p_scl && !cs && mode != 0) begin
      if (bitc == 8) begin
        if (mode == 3) slv_sda <= 1'b1;
        else begin
          if (exp_wr.size() == 0) chk(0, "R2/R3 unexpected byte", int'(sh), -1);
          else begin
            logic [7:0] e;
            e = exp_wr.pop_front();
            chk(sh == e, "R2/R3 bus byte", int'(sh), int'(e));
          end
          if (mode == 1) begin
            ack = !nack_addr;
            nxt_mode = !ack ? 0 : (sh[0] ? 3 : 2);
          end else begin
            ack = (wr_idx != nack_idx);
            wr_idx++;
          end
          slv_sda <= !ack;
        end
      end else if (bitc == 9) begin
        bitc = 0;
        if (mode == 1) mode = nxt_mode;
        if (mode == 3 && !rd_stop) begin
          rd_byte = 8'hA0 + 8'(rd_k);
          rd_k++;
          slv_sda <= rd_byte[7];
        end else slv_sda <= 1'b1;
      end else if (mode == 3 && !rd_stop && bitc >= 1 && bitc <= 7) begin
        slv_sda <= rd_byte[7-bitc];
      end
    end
    p_scl = cs;
    p_sda = cd;
  end

  // TX driver
  bit tx_hs = 0;
  always @(posedge clk) tx_hs <= tx_valid && tx_ready;
  always @(negedge clk) begin
    if (tx_hs && tx_q.size() > 0) void'(tx_q.pop_front());
    tx_valid = (tx_q.size() > 0);
    tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
  end

  // RX monitor
  always @(negedge clk) begin
    if (rx_valid && rx_ready) begin
      if (exp_rd.size() == 0) chk(0, "R4/R10 unexpected rx", int'(rx_data), -1);
      else begin
        logic [7:0] e;
        e = exp_rd.pop_front();
        chk(rx_data == e, "R4/R10 rx byte", int'(rx_data), int'(e));
      end
    end
  end

  // pulse bookkeeping
  int cyc = 0, done_cnt = 0, err_cnt = 0, err_cyc = 0, done_cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (rst_n && xfer_done) begin done_cnt++; done_cyc = cyc; end
    if (rst_n && ack_err)   begin err_cnt++;  err_cyc = cyc;  end
  end

  task automatic clr();
    starts = 0; stops = 0; m_acks = 0; m_nacks = 0; wr_idx = 0;
    done_cnt = 0; err_cnt = 0; nack_idx = -1; nack_addr = 0;
  endtask

  task automatic push_wr(input logic [6:0] a, input int n, input logic [7:0] seed);
    exp_wr.push_back({a, 1'b0});
    for (int i = 0; i < n; i++) begin
      exp_wr.push_back(seed + 8'(i));
      tx_q.push_back(seed + 8'(i));
    end
  endtask

  task automatic push_rd(input logic [6:0] a, input int n);
    exp_wr.push_back({a, 1'b1});
    for (int i = 0; i < n; i++) begin
      exp_rd.push_back(8'hA0 + 8'(exp_k));
      exp_k++;
    end
  endtask

  task automatic launch(input logic [6:0] a, input bit rd, input logic [15:0] len,
                        input logic [7:0] cnt, input logic [7:0] c);
    @(negedge clk);
    tgt_addr = a; rd_op = rd; xfer_len = len; txn_cnt = cnt; ctl = c; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (!xfer_done) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(scl_o && sda_o, "R1 lines released", int'({scl_o, sda_o}), 3);
    chk(!busy && !xfer_done && !ack_err, "R1 idle status", int'({busy, xfer_done, ack_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 single write of 3 bytes
    clr(); push_wr(7'h2C, 3, 8'h31);
    launch(7'h2C, 0, 16'h0003, 8'd1, 8'h20);
    chk(starts == 1 && stops == 1, "R3 one start one stop", starts*10+stops, 11);
    chk(exp_wr.size() == 0 && tx_q.size() == 0, "R3 all bytes sent", exp_wr.size(), 0);
    chk(done_cnt == 1 && err_cnt == 0, "R12 single done", done_cnt*10+err_cnt, 10);

    // R2 R5 single read of 4 bytes
    clr(); push_rd(7'h51, 4);
    launch(7'h51, 1, 16'h0004, 8'd1, 8'h20);
    chk(m_acks == 3 && m_nacks == 1, "R5 ack pattern", m_acks*10+m_nacks, 31);
    chk(exp_rd.size() == 0, "R2 read data delivered", exp_rd.size(), 0);

    // R4 combined: 2 written, 3 read
    clr(); push_wr(7'h3A, 2, 8'h70); push_rd(7'h3A, 3);
    launch(7'h3A, 1, 16'h0302, 8'd2, 8'h32);
    chk(starts == 2 && stops == 1, "R4 repeated start no stop", starts*10+stops, 21);
    chk(exp_wr.size() == 0 && exp_rd.size() == 0, "R4 both phases", exp_wr.size()+exp_rd.size(), 0);
    chk(m_nacks == 1 && m_acks == 2, "R5 combined ack pattern", m_acks*10+m_nacks, 21);

    // R6 bits 15:13 ignored: 0xE2 -> read length 2
    clr(); push_wr(7'h11, 1, 8'h05); push_rd(7'h11, 2);
    launch(7'h11, 0, 16'hE201, 8'd2, 8'h30);
    chk(m_acks + m_nacks == 2, "R6 read length field", m_acks+m_nacks, 2);
    chk(exp_rd.size() == 0, "R6 read bytes", exp_rd.size(), 0);

    // R7 address NACK with detection
    clr(); nack_addr = 1; exp_wr.push_back({7'h66, 1'b0});
    tx_q.push_back(8'hC1); tx_q.push_back(8'hC2);
    launch(7'h66, 0, 16'h0002, 8'd1, 8'h20);
    chk(err_cnt == 1 && done_cnt == 1, "R7 err and done", err_cnt*10+done_cnt, 11);
    chk(err_cyc < done_cyc, "R7 err precedes done", err_cyc, done_cyc);
    chk(tx_q.size() == 2 && stops == 1, "R7 no data after abort", tx_q.size(), 2);
    tx_q.delete();

    // R7 data NACK with detection: third byte not sent
    clr(); nack_idx = 1; push_wr(7'h22, 2, 8'h90);
    tx_q.push_back(8'h92);
    launch(7'h22, 0, 16'h0003, 8'd1, 8'h20);
    chk(err_cnt == 1 && tx_q.size() == 1, "R7 data nack abort", tx_q.size(), 1);
    tx_q.delete();

    // R8 data NACK ignored
    clr(); nack_idx = 1; push_wr(7'h22, 3, 8'hB0);
    launch(7'h22, 0, 16'h0003, 8'd1, 8'h00);
    chk(err_cnt == 0 && exp_wr.size() == 0, "R8 nack ignored", err_cnt, 0);

    // R9 three writes with repeated start
    clr(); push_wr(7'h0F, 1, 8'h01); push_wr(7'h0F, 1, 8'h01); push_wr(7'h0F, 1, 8'h01);
    launch(7'h0F, 0, 16'h0001, 8'd3, 8'h22);
    chk(starts == 3 && stops == 1, "R9 repeated starts", starts*10+stops, 31);
    chk(done_cnt == 1 && exp_wr.size() == 0, "R12 one done for three", done_cnt, 1);

    // R9 two writes with stop between
    clr(); push_wr(7'h0E, 1, 8'h44); push_wr(7'h0E, 1, 8'h44);
    launch(7'h0E, 0, 16'h0001, 8'd2, 8'h20);
    chk(starts == 2 && stops == 2, "R9 stop between", starts*10+stops, 22);

    // R10 rx back-pressure
    clr(); push_rd(7'h48, 2);
    rx_ready = 1'b0;
    @(negedge clk);
    tgt_addr = 7'h48; rd_op = 1; xfer_len = 16'h0002; txn_cnt = 8'd1; ctl = 8'h20; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (!rx_valid) @(negedge clk);
    begin
      logic [7:0] held;
      bit steady;
      held = rx_data;
      steady = 1;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (!rx_valid || rx_data != held || scl_o) steady = 0;
      end
      chk(steady, "R10 held during stall", int'(steady), 1);
    end
    rx_ready = 1'b1;
    while (!xfer_done) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(exp_rd.size() == 0, "R10 data after stall", exp_rd.size(), 0);

    // R11 zero count
    clr();
    launch(7'h10, 0, 16'h0005, 8'd0, 8'h20);
    chk(starts == 0 && done_cnt == 1, "R11 no bus activity", starts, 0);
    chk(scl_o && sda_o && !busy, "R1 idle after", int'({scl_o, sda_o, busy}), 6);

    finish_run();
  end

endmodule